// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block sends 8-bit characters as asynchronous serial frames: one low start bit, eight data bits with the least significant bit first, and one high stop bit. Between frames the line rests high. The block has one holding register in front of the shift register. Software can therefore queue the next character while the current one is still on the line. When the shift register finishes its stop bit and a character is waiting, the next start bit follows at once.

Two flags report progress. The holding-empty flag means another character may be written. The line-done flag means the last frame has fully left the wire and nothing is queued, which is the moment a half-duplex node can release the bus. Each flag has its own interrupt enable, and the holding-empty request is also gated by a global interrupt enable input. The line-done flag is cleared by writing a one to its status bit or by an acknowledge pulse. A speed bit selects 16 or 8 clocks per bit. One status byte carries the flags and the writable control bits.

Top module: `uart_dbl_tx`

## Requirements
- R1: After reset the holding-empty flag is 1, the line-done flag is 0, both interrupt enables and the speed bit are 0, both interrupt outputs are 0 and the line is high.
- R2: Each frame is a low start bit, then data bits 0 to 7 in that order, then a high stop bit; the line is high when no frame is being sent.
- R3: Every bit of a frame lasts 16 clock cycles when status bit 4 (speed) is 0 and 8 clock cycles when it is 1.
- R4: A data write accepted while the holding-empty flag is 1 clears that flag in the following cycle. A data write made while the flag is 0 is dropped: that character is never sent and the queued one is not changed.
- R5: The holding-empty flag returns to 1 in the same cycle that the queued character's start bit appears on the line.
- R6: When a character is queued before the current stop bit ends, its start bit begins on the first cycle after that stop bit, so two start bits lie exactly ten bit times apart.
- R7: The line-done flag sets only when a stop bit ends with no character queued. It does not set between back-to-back frames.
- R8: The line-done flag clears on a status write with bit 1 set, or on a one-cycle acknowledge pulse. A status write with bit 1 clear leaves the flag unchanged.
- R9: The holding-empty interrupt output is high exactly while the holding-empty flag, its enable (status bit 2) and the global enable input are all 1.
- R10: The line-done interrupt output is high exactly while the line-done flag and its enable (status bit 3) are both 1.
- R11: Status read layout: bit 0 holding-empty, bit 1 line-done, bit 2 empty-interrupt enable, bit 3 done-interrupt enable, bit 4 speed; bits 7:5 read 0. A status write loads bits 2 to 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_data_i | input | 1 | Data write strobe, one cycle per character |
| wdata_i | input | 8 | Character to queue |
| stat_wr_i | input | 1 | Status write strobe |
| stat_wdata_i | input | 8 | Status write value (bit 1 write-one-to-clear, bits 4:2 control) |
| stat_rdata_o | output | 8 | Status read value |
| gie_i | input | 1 | Global interrupt enable |
| done_ack_i | input | 1 | Line-done interrupt acknowledge pulse |
| txd_o | output | 1 | Serial line output, idles high |
| irq_empty_o | output | 1 | Holding-empty interrupt request |
| irq_done_o | output | 1 | Line-done interrupt request |

## Verification
The properties assume that reset is applied at start-up, that strobes are single-cycle, and that the speed bit is changed only while the line is idle and nothing is queued. Under those conditions a rise of the empty flag coincides with a low start bit, and a low line means no stop bit can be ending. The stimulus changes the speed bit only after the line-done flag has been seen set. It issues data writes either after polling the empty flag or, on purpose, while it is clear. It pulses acknowledge and write-one-to-clear at random points, both mid-frame and at idle.

// File: rtl/utx_pkg.sv
package utx_pkg;

    localparam int CHAR_W     = 8;
    localparam int FRAME_BITS = CHAR_W + 2;
    localparam int STAT_W     = 8;

    // status byte bit positions
    localparam int ST_EMPTY    = 0;
    localparam int ST_DONE     = 1;
    localparam int ST_IE_EMPTY = 2;
    localparam int ST_IE_DONE  = 3;
    localparam int ST_DBL      = 4;

    typedef enum logic {
        SH_IDLE = 1'b0,
        SH_BUSY = 1'b1
    } sh_state_e;

    typedef struct packed {
        logic dbl;
        logic ie_done;
        logic ie_empty;
    } utx_ctrl_t;

    localparam utx_ctrl_t CTRL_RST = '{dbl: 1'b0, ie_done: 1'b0, ie_empty: 1'b0};

    // stop bit in the top position, start bit in bit 0, shifted out LSB first
    function automatic logic [FRAME_BITS-1:0] build_frame(input logic [CHAR_W-1:0] ch);
        return {1'b1, ch, 1'b0};
    endfunction

    function automatic utx_ctrl_t ctrl_from_bus(input logic [STAT_W-1:0] v);
        utx_ctrl_t c;
        c.dbl      = v[ST_DBL];
        c.ie_done  = v[ST_IE_DONE];
        c.ie_empty = v[ST_IE_EMPTY];
        return c;
    endfunction

    function automatic logic [STAT_W-1:0] status_pack(input logic empty,
                                                      input logic done,
                                                      input utx_ctrl_t c);
        logic [STAT_W-1:0] s;
        s              = '0;
        s[ST_EMPTY]    = empty;
        s[ST_DONE]     = done;
        s[ST_IE_EMPTY] = c.ie_empty;
        s[ST_IE_DONE]  = c.ie_done;
        s[ST_DBL]      = c.dbl;
        return s;
    endfunction

endpackage

// File: rtl/utx_baud.sv
module utx_baud #(
    parameter int OVS_NORM = 16,
    parameter int OVS_DBL  = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic dbl,
    output logic tick
);
    localparam int CNT_W = (OVS_NORM > 1) ? $clog2(OVS_NORM) : 1;
    localparam logic [CNT_W-1:0] LIM_NORM = CNT_W'(OVS_NORM - 1);
    localparam logic [CNT_W-1:0] LIM_DBL  = CNT_W'(OVS_DBL - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    always_comb begin
        lim  = dbl ? LIM_DBL : LIM_NORM;
        tick = (cnt >= lim);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/utx_hold.sv
module utx_hold
    import utx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [CHAR_W-1:0] wdata,
    input  logic              take,
    output logic              full,
    output logic [CHAR_W-1:0] data
);
    logic accept;

    always_comb begin
        accept = wr && !full;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            data <= '0;
        end else begin
            if (accept) begin
                full <= 1'b1;
                data <= wdata;
            end else if (take) begin
                full <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/utx_shift.sv
module utx_shift
    import utx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              hold_full,
    input  logic [CHAR_W-1:0] hold_data,
    output logic              take,
    output logic              done_set,
    output logic              txd
);
    localparam int IDX_W = $clog2(FRAME_BITS);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);

    sh_state_e             state;
    logic [FRAME_BITS-1:0] shreg;
    logic [IDX_W-1:0]      idx;
    logic                  last;

    always_comb begin
        last     = (state == SH_BUSY) && (idx == IDX_LAST);
        take     = tick && hold_full && ((state == SH_IDLE) || last);
        done_set = tick && last && !hold_full;
        txd      = (state == SH_BUSY) ? shreg[0] : 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SH_IDLE;
            shreg <= '1;
            idx   <= '0;
        end else if (tick) begin
            if (take) begin
                state <= SH_BUSY;
                shreg <= build_frame(hold_data);
                idx   <= '0;
            end else if (last) begin
                state <= SH_IDLE;
                shreg <= '1;
                idx   <= '0;
            end else if (state == SH_BUSY) begin
                shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
                idx   <= idx + IDX_W'(1);
            end
        end
    end

endmodule

// File: rtl/uart_dbl_tx.sv
module uart_dbl_tx
    import utx_pkg::*;
#(
    parameter int OVS_NORM = 16,
    parameter int OVS_DBL  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_data_i,
    input  logic [CHAR_W-1:0] wdata_i,
    input  logic              stat_wr_i,
    input  logic [STAT_W-1:0] stat_wdata_i,
    output logic [STAT_W-1:0] stat_rdata_o,
    input  logic              gie_i,
    input  logic              done_ack_i,
    output logic              txd_o,
    output logic              irq_empty_o,
    output logic              irq_done_o
);
    utx_ctrl_t         ctrl;
    logic              done_q;
    logic              tick;
    logic              hold_full;
    logic [CHAR_W-1:0] hold_data;
    logic              take;
    logic              done_set;
    logic              done_clr;
    logic              empty;

    utx_baud #(
        .OVS_NORM (OVS_NORM),
        .OVS_DBL  (OVS_DBL)
    ) baud_i (
        .clk  (clk),
        .rst  (rst),
        .dbl  (ctrl.dbl),
        .tick (tick)
    );

    utx_hold hold_i (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr_data_i),
        .wdata (wdata_i),
        .take  (take),
        .full  (hold_full),
        .data  (hold_data)
    );

    utx_shift shift_i (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .take      (take),
        .done_set  (done_set),
        .txd       (txd_o)
    );

    always_comb begin
        empty        = !hold_full;
        done_clr     = done_ack_i || (stat_wr_i && stat_wdata_i[ST_DONE]);
        stat_rdata_o = status_pack(empty, done_q, ctrl);
        irq_empty_o  = empty && ctrl.ie_empty && gie_i;
        irq_done_o   = done_q && ctrl.ie_done;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= CTRL_RST;
            done_q <= 1'b0;
        end else begin
            if (stat_wr_i) begin
                ctrl <= ctrl_from_bus(stat_wdata_i);
            end
            // a fresh completion event wins over a clear in the same cycle
            if (done_set) begin
                done_q <= 1'b1;
            end else if (done_clr) begin
                done_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/uart_dbl_tx_chk.sv
module uart_dbl_tx_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_data_i,
    input logic       stat_wr_i,
    input logic [7:0] stat_wdata_i,
    input logic [7:0] stat_rdata_o,
    input logic       gie_i,
    input logic       done_ack_i,
    input logic       txd_o,
    input logic       irq_empty_o,
    input logic       irq_done_o
);

    a_r4_empty_clears: assert property (@(posedge clk) disable iff (rst)
        (wr_data_i && stat_rdata_o[0]) |=> !stat_rdata_o[0]);

    a_r5_empty_with_start: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_rdata_o[0]) |-> !txd_o);

    a_r7_done_line_high: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_rdata_o[1]) |-> txd_o);

    a_r8_clear_midframe: assert property (@(posedge clk) disable iff (rst)
        ((done_ack_i || (stat_wr_i && stat_wdata_i[1])) && !txd_o) |=> !stat_rdata_o[1]);

    a_r9_gie_gates: assert property (@(posedge clk) disable iff (rst)
        !gie_i |-> !irq_empty_o);

    a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        irq_done_o |-> stat_rdata_o[1]);

endmodule

bind uart_dbl_tx uart_dbl_tx_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .wr_data_i    (wr_data_i),
    .stat_wr_i    (stat_wr_i),
    .stat_wdata_i (stat_wdata_i),
    .stat_rdata_o (stat_rdata_o),
    .gie_i        (gie_i),
    .done_ack_i   (done_ack_i),
    .txd_o        (txd_o),
    .irq_empty_o  (irq_empty_o),
    .irq_done_o   (irq_done_o)
);

// File: tb/uart_dbl_tx_tb_top.sv
module uart_dbl_tx_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_data_i = 1'b0;
    logic [7:0] wdata_i = '0;
    logic       stat_wr_i = 1'b0;
    logic [7:0] stat_wdata_i = '0;
    logic [7:0] stat_rdata_o;
    logic       gie_i = 1'b0;
    logic       done_ack_i = 1'b0;
    logic       txd_o;
    logic       irq_empty_o;
    logic       irq_done_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int cur_bt = 16;
    logic [7:0] rx_q[$];
    int         rx_t0[$];
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    uart_dbl_tx dut_i (
        .clk          (clk),
        .rst          (rst),
        .wr_data_i    (wr_data_i),
        .wdata_i      (wdata_i),
        .stat_wr_i    (stat_wr_i),
        .stat_wdata_i (stat_wdata_i),
        .stat_rdata_o (stat_rdata_o),
        .gie_i        (gie_i),
        .done_ack_i   (done_ack_i),
        .txd_o        (txd_o),
        .irq_empty_o  (irq_empty_o),
        .irq_done_o   (irq_done_o)
    );

    function automatic logic [7:0] ctrl_byte(input logic dbl, input logic ie_d,
                                             input logic ie_e, input logic w1c);
        return {3'b000, dbl, ie_d, ie_e, w1c, 1'b0};
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // watchdog
    initial begin
        #(5 * 150000);
        errors++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        finish_run();
    end

    // line receiver: checks every bit at its first and its last cycle (R2, R3)
    initial begin
        logic [9:0] bits;
        logic a;
        logic b;
        int t0;
        int bt;
        forever begin
            @(negedge clk); #1;
            if (!rst && !txd_o) begin
                t0 = cyc;
                bt = cur_bt;
                for (int k = 0; k < 10; k++) begin
                    a = txd_o;
                    repeat (bt - 1) @(negedge clk);
                    #1;
                    b = txd_o;
                    chk(a == b, "R3 bit level held for the whole bit time", int'(b), int'(a));
                    bits[k] = a;
                    if (k < 9) begin
                        @(negedge clk); #1;
                    end
                end
                chk(bits[0] == 1'b0, "R2 start bit low", int'(bits[0]), 0);
                chk(bits[9] == 1'b1, "R2 stop bit high", int'(bits[9]), 1);
                rx_q.push_back(bits[8:1]);
                rx_t0.push_back(t0);
            end
        end
    end

    task automatic write_data(input logic [7:0] b);
        @(negedge clk);
        wr_data_i = 1'b1;
        wdata_i   = b;
        @(negedge clk);
        wr_data_i = 1'b0;
        #1;
    endtask

    task automatic write_stat(input logic [7:0] v);
        @(negedge clk);
        stat_wr_i    = 1'b1;
        stat_wdata_i = v;
        @(negedge clk);
        stat_wr_i    = 1'b0;
        #1;
    endtask

    task automatic wait_empty();
        int n = 0;
        @(negedge clk); #1;
        while (!stat_rdata_o[0] && n < 400) begin
            @(negedge clk); #1;
            n++;
        end
        chk(stat_rdata_o[0] == 1'b1, "R5 holding register drains", int'(stat_rdata_o[0]), 1);
    endtask

    task automatic wait_rx(input int n);
        int k = 0;
        while (rx_q.size() < n && k < 4000) begin
            @(negedge clk); #1;
            k++;
        end
        chk(rx_q.size() >= n, "R2 frame received", rx_q.size(), n);
        @(negedge clk); #1;
        @(negedge clk); #1;
    endtask

    task automatic wait_start();
        int k = 0;
        while (txd_o && k < 40) begin
            @(negedge clk); #1;
            k++;
        end
    endtask

    initial begin
        int base;
        logic [7:0] b;
        logic dbl;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;

        // R1 / R11 reset state
        chk(stat_rdata_o == 8'h01, "R1 R11 status after reset", stat_rdata_o, 8'h01);
        chk(txd_o == 1'b1, "R1 line high after reset", txd_o, 1);
        chk(!irq_empty_o && !irq_done_o, "R1 no interrupt after reset",
            {irq_empty_o, irq_done_o}, 0);

        // single frame at normal speed
        write_data(8'hA5);
        chk(stat_rdata_o[0] == 1'b0, "R4 empty clears after write", stat_rdata_o[0], 0);
        wait_start();
        chk(!txd_o, "R2 start bit appears", txd_o, 0);
        chk(stat_rdata_o[0] == 1'b1, "R5 empty set with start bit", stat_rdata_o[0], 1);
        chk(stat_rdata_o[1] == 1'b0, "R7 done clear while sending", stat_rdata_o[1], 0);
        exp_q.push_back(8'hA5);
        wait_rx(1);
        chk(rx_q[0] == 8'hA5, "R2 data LSB first", rx_q[0], 8'hA5);
        chk(stat_rdata_o[1] == 1'b1, "R7 done set after stop bit", stat_rdata_o[1], 1);
        chk(txd_o == 1'b1, "R2 line idles high", txd_o, 1);

        // R8 write zero leaves flag, write one clears it
        write_stat(ctrl_byte(1'b0, 1'b0, 1'b0, 1'b0));
        chk(stat_rdata_o[1] == 1'b1, "R8 write zero keeps done", stat_rdata_o[1], 1);
        write_stat(ctrl_byte(1'b0, 1'b0, 1'b0, 1'b1));
        chk(stat_rdata_o[1] == 1'b0, "R8 write one clears done", stat_rdata_o[1], 0);

        // back-to-back at normal speed
        write_data(8'h3C);
        exp_q.push_back(8'h3C);
        wait_empty();
        write_data(8'hC3);
        exp_q.push_back(8'hC3);
        wait_empty();
        chk(stat_rdata_o[1] == 1'b0, "R7 no done between back-to-back frames",
            stat_rdata_o[1], 0);
        wait_rx(3);
        chk(rx_t0[2] - rx_t0[1] == 10 * 16, "R6 no gap between frames",
            rx_t0[2] - rx_t0[1], 160);
        chk(stat_rdata_o[1] == 1'b1, "R7 done after last frame", stat_rdata_o[1], 1);
        write_stat(ctrl_byte(1'b0, 1'b0, 1'b0, 1'b1));

        // R4 write while full is dropped
        write_data(8'h11);
        exp_q.push_back(8'h11);
        write_data(8'hEE);
        wait_rx(4);
        repeat (12 * 16) @(negedge clk);
        #1;
        chk(rx_q.size() == 4, "R4 write while full not sent", rx_q.size(), 4);
        chk(rx_q[3] == 8'h11, "R4 queued character kept", rx_q[3], 8'h11);
        write_stat(ctrl_byte(1'b0, 1'b0, 1'b0, 1'b1));

        // double speed, back-to-back
        write_stat(ctrl_byte(1'b1, 1'b0, 1'b0, 1'b0));
        cur_bt = 8;
        chk(stat_rdata_o == 8'h11, "R11 speed bit reads back", stat_rdata_o, 8'h11);
        write_data(8'h5A);
        exp_q.push_back(8'h5A);
        wait_empty();
        write_data(8'h81);
        exp_q.push_back(8'h81);
        wait_rx(6);
        chk(rx_t0[5] - rx_t0[4] == 10 * 8, "R3 R6 double-speed frame spacing",
            rx_t0[5] - rx_t0[4], 80);
        write_stat(ctrl_byte(1'b1, 1'b0, 1'b0, 1'b1));

        // R9 empty interrupt gating
        write_stat(ctrl_byte(1'b1, 1'b0, 1'b1, 1'b0));
        gie_i = 1'b0;
        @(negedge clk); #1;
        chk(!irq_empty_o, "R9 global enable low blocks request", irq_empty_o, 0);
        gie_i = 1'b1;
        #1;
        chk(irq_empty_o, "R9 request with all enables", irq_empty_o, 1);
        write_data(8'h96);
        exp_q.push_back(8'h96);
        chk(!irq_empty_o, "R9 request drops when register full", irq_empty_o, 0);
        wait_empty();
        chk(irq_empty_o, "R9 request returns on transfer", irq_empty_o, 1);
        gie_i = 1'b0;

        // R10 done interrupt and acknowledge clear
        write_stat(ctrl_byte(1'b1, 1'b1, 1'b0, 1'b0));
        chk(!irq_done_o, "R10 no request while sending", irq_done_o, 0);
        wait_rx(7);
        chk(irq_done_o, "R10 request after completion", irq_done_o, 1);
        @(negedge clk);
        done_ack_i = 1'b1;
        @(negedge clk);
        done_ack_i = 1'b0;
        #1;
        chk(stat_rdata_o[1] == 1'b0, "R8 acknowledge clears done", stat_rdata_o[1], 0);
        chk(!irq_done_o, "R10 request drops after acknowledge", irq_done_o, 0);

        // random bursts
        for (int burst = 0; burst < 10; burst++) begin
            dbl = 1'($urandom_range(0, 1));
            write_stat(ctrl_byte(dbl, 1'b0, 1'b0, 1'b1));
            cur_bt = dbl ? 8 : 16;
            for (int c = 0; c < 4; c++) begin
                b = 8'($urandom_range(0, 255));
                wait_empty();
                repeat ($urandom_range(0, 20)) @(negedge clk);
                write_data(b);
                exp_q.push_back(b);
                if ($urandom_range(0, 3) == 0) begin
                    write_stat(ctrl_byte(dbl, 1'b0, 1'b0, 1'b1));
                end
            end
            wait_rx(exp_q.size());
            chk(stat_rdata_o[1] == 1'b1, "R7 done after burst", stat_rdata_o[1], 1);
        end

        base = (rx_q.size() < exp_q.size()) ? rx_q.size() : exp_q.size();
        chk(rx_q.size() == exp_q.size(), "R4 frame count", rx_q.size(), exp_q.size());
        for (int i = 0; i < base; i++) begin
            chk(rx_q[i] == exp_q[i], "R2 character content", rx_q[i], exp_q[i]);
        end
        finish_run();
    end

endmodule